// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block lets an external microcontroller reach a bank of byte registers over eight shared lines and three control strobes. The controller first puts an address on the shared lines and pulses the address-latch strobe. It then moves data over the same lines, using a read strobe or a write strobe for each byte. After every completed data access the internal address pointer steps forward by one. A block transfer therefore needs only one address phase, which keeps a sustained rate of roughly ten megabytes per second within reach.

All three strobes and the shared lines are asynchronous to the much faster system clock. Each one passes through a synchronizer chain before the block acts on it. The block acts on edges, not levels, so holding a strobe down longer never repeats its action. The shared lines appear as a separate input, an output and an output enable. During a read the block drives the output with the addressed register and asserts the enable. At all other times the enable is low and the lines are left to the master.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset the output enable is low, the address pointer is 0 and every register reads 0.
- R2: A rising address-latch strobe loads the address pointer with the value on the shared lines.
- R3: A rising write strobe stores the value on the shared lines into the register at the pointer, provided the read strobe is low.
- R4: When an accepted write strobe is released, the pointer increments by one.
- R5: While an accepted read strobe is held, the output enable is high and the output carries the register at the pointer. With no read in progress the output enable is low.
- R6: When an accepted read strobe is released, the pointer increments by one.
- R7: The pointer wraps from the last register (255 with default parameters) to 0, for both reads and writes.
- R8: An address-latch strobe replaces the pointer at any moment, whatever accesses came before it.
- R9: If the read and write strobes are high together, nothing is written, the output enable stays low and the pointer does not move.
- R10: Each strobe assertion causes exactly one action, however long it is held. A write keeps the value sampled at its leading edge, even if the shared lines change while the strobe is still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad_i | input | 8 | Shared address/data lines as seen by the block |
| bus_ad_o | output | 8 | Value the block drives onto the shared lines during a read |
| bus_ad_oe | output | 1 | Output enable for the shared lines, high only during a read |
| ale_i | input | 1 | Address-latch strobe, active high, asynchronous |
| rd_i | input | 1 | Read strobe, active high, asynchronous |
| wr_i | input | 1 | Write strobe, active high, asynchronous |

## Verification
The bench goes after the following corner cases:
- **Pointer wrap.** Bursts cross the top of the register space in both directions. A pointer that saturates instead of wrapping would write the final byte over the last register, and would read the last register twice.
- **Late address latch.** An address latch arrives after a burst has already moved the pointer. A design that let the increment win would land the next byte one register too far.
- **Overlapping strobes.** The read and write strobes are raised together. A design that did not handle this would write stray data, or drive the lines while the master also drives them. A following write then shows whether the pointer skipped a register.
- **Long write with changing data.** A write strobe is held while the data changes underneath it. This exposes level-triggered logic, which would store the later value or step the pointer more than once.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
   // positions of the control strobes inside the synchronized strobe vector
   localparam int unsigned STB_ALE = 0;
   localparam int unsigned STB_RD  = 1;
   localparam int unsigned STB_WR  = 2;
   localparam int unsigned STB_N   = 3;

   typedef struct packed {
      logic ld;     // load pointer from bus
      logic we;     // commit write
      logic inc;    // step pointer
   } mbs_ctl_t;
endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbs_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mbs_strobe.sv
module mbs_strobe #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stb_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   logic [W-1:0] prev;

   mbs_sync #(.W(W), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (stb_i),
      .q_o   (lvl_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= lvl_o;
   end

   assign rise_o = lvl_o & ~prev;
   assign fall_o = ~lvl_o & prev;

   AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o & fall_o) == '0); // R10
   AST_RISE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R10
endmodule

// File: rtl/mbs_addr_ctr.sv
module mbs_addr_ctr #(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          inc_i,
   output logic [AW-1:0] addr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      addr_o <= '0;
      else if (load_i) addr_o <= load_val_i;
      else if (inc_i)  addr_o <= addr_o + 1'b1;
   end

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> addr_o == $past(load_val_i)); // R8
   AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i && addr_o == {AW{1'b1}}) |=> addr_o == '0); // R7
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(addr_o)); // R9
endmodule

// File: rtl/mbs_regbank.sv
module mbs_regbank #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);
   logic [DW-1:0] mem [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[e] <= '0;
            else if (we_i && addr_i == AW'(e))
               mem[e] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ADDR_W     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_ad_i,
   output logic [DATA_W-1:0] bus_ad_o,
   output logic              bus_ad_oe,
   input  logic              ale_i,
   input  logic              rd_i,
   input  logic              wr_i
);
   import mbs_pkg::*;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("address must fit on the shared lines");
      end
      if ((1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
   endgenerate

   logic [STB_N-1:0]  stb_lvl, stb_rise, stb_fall;
   logic [DATA_W-1:0] din_s;
   logic [DATA_W-1:0] rdata;
   logic [ADDR_W-1:0] addr;
   logic              rd_act, wr_act;
   logic              rd_go, wr_go;
   mbs_ctl_t          ctl;

   mbs_strobe #(.W(STB_N), .STAGES(SYNC_STAGES)) u_stb (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  ({wr_i, rd_i, ale_i}),
      .lvl_o  (stb_lvl),
      .rise_o (stb_rise),
      .fall_o (stb_fall)
   );

   // data travels through the same depth so it lines up with the strobe edges
   mbs_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_dsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_ad_i),
      .q_o   (din_s)
   );

   always_comb begin
      rd_go   = stb_rise[STB_RD] & ~stb_lvl[STB_WR];
      wr_go   = stb_rise[STB_WR] & ~stb_lvl[STB_RD];
      ctl.ld  = stb_rise[STB_ALE];
      ctl.we  = wr_go;
      ctl.inc = (stb_fall[STB_RD] & rd_act) | (stb_fall[STB_WR] & wr_act);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act <= 1'b0;
         wr_act <= 1'b0;
      end else if (ctl.ld) begin
         rd_act <= 1'b0;
         wr_act <= 1'b0;
      end else begin
         if (rd_go)                                      rd_act <= 1'b1;
         else if (stb_lvl[STB_WR] || stb_fall[STB_RD])   rd_act <= 1'b0;
         if (wr_go)                                      wr_act <= 1'b1;
         else if (stb_lvl[STB_RD] || stb_fall[STB_WR])   wr_act <= 1'b0;
      end
   end

   mbs_addr_ctr #(.AW(ADDR_W)) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ctl.ld),
      .load_val_i (din_s[ADDR_W-1:0]),
      .inc_i      (ctl.inc),
      .addr_o     (addr)
   );

   mbs_regbank #(.DW(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (ctl.we),
      .addr_i  (addr),
      .wdata_i (din_s),
      .rdata_o (rdata)
   );

   assign bus_ad_oe = rd_act;
   assign bus_ad_o  = rd_act ? rdata : '0;

   AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ad_oe |-> (stb_lvl[STB_RD] || stb_fall[STB_RD])); // R5
   AST_OE_NOT_IN_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_lvl[STB_RD] && stb_lvl[STB_WR]) |=> !bus_ad_oe); // R9
   AST_WRITE_NOT_IN_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.we |-> !stb_lvl[STB_RD]); // R9
   AST_WRITE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.we |=> !ctl.we); // R10
   AST_INC_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.inc |-> (rd_act || wr_act)); // R4
endmodule

// File: tb/mux_bus_slave_bench.sv
module mux_bus_slave_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_ad_i = '0;
   logic [7:0] bus_ad_o;
   logic       bus_ad_oe;
   logic       ale_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
   int         checks = 0, failures = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   mux_bus_slave u_mux_bus_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_ad_i  (bus_ad_i),
      .bus_ad_o  (bus_ad_o),
      .bus_ad_oe (bus_ad_oe),
      .ale_i     (ale_i),
      .rd_i      (rd_i),
      .wr_i      (wr_i)
   );

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic set_addr(input logic [7:0] a);
      bus_ad_i = a; wait_cyc(1);
      ale_i = 1'b1; wait_cyc(6);
      ale_i = 1'b0; wait_cyc(6);
   endtask

   task automatic wr_byte(input logic [7:0] d);
      bus_ad_i = d; wait_cyc(1);
      wr_i = 1'b1; wait_cyc(6);
      wr_i = 1'b0; wait_cyc(6);
   endtask

   task automatic rd_byte(input logic [7:0] exp, input string req);
      bus_ad_i = 8'h5A;
      rd_i = 1'b1; wait_cyc(6);
      check({req, " oe"}, {8'h00, bus_ad_oe}, 9'h001);
      check({req, " data"}, {1'b0, bus_ad_o}, {1'b0, exp});
      rd_i = 1'b0; wait_cyc(6);
      check({req, " oe release"}, {8'h00, bus_ad_oe}, 9'h000);
   endtask

   task automatic t_reset;
      check("R1 oe after reset", {8'h00, bus_ad_oe}, 9'h000);
      rd_byte(8'h00, "R1 reg0 after reset");
      rd_byte(8'h00, "R1 reg1 after reset");
   endtask

   task automatic t_burst;
      set_addr(8'h10);
      wr_byte(8'hA1); wr_byte(8'hB2); wr_byte(8'hC3);      // R3 R4
      check("R5 idle oe", {8'h00, bus_ad_oe}, 9'h000);
      set_addr(8'h10);                                     // R2
      rd_byte(8'hA1, "R2 R3 first");
      rd_byte(8'hB2, "R4 R6 second");
      rd_byte(8'hC3, "R6 third");
   endtask

   task automatic t_wrap;
      set_addr(8'hFE);
      wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33);
      set_addr(8'h00);
      rd_byte(8'h33, "R7 write wrapped to 0");
      set_addr(8'hFE);
      rd_byte(8'h11, "R7 reg FE");
      rd_byte(8'h22, "R7 reg FF");
      rd_byte(8'h33, "R7 read wrap");
   endtask

   task automatic t_override;
      set_addr(8'h40);
      wr_byte(8'h01);
      set_addr(8'h20);
      wr_byte(8'h77);
      set_addr(8'h20);
      rd_byte(8'h77, "R8 relatched target");
      set_addr(8'h41);
      rd_byte(8'h00, "R8 old pointer untouched");
   endtask

   task automatic t_clash;
      set_addr(8'h30);
      wr_byte(8'h55);
      bus_ad_i = 8'h99; wait_cyc(1);
      rd_i = 1'b1; wr_i = 1'b1; wait_cyc(6);
      check("R9 oe during clash", {8'h00, bus_ad_oe}, 9'h000);
      rd_i = 1'b0; wr_i = 1'b0; wait_cyc(6);
      wr_byte(8'hAA);
      set_addr(8'h30);
      rd_byte(8'h55, "R9 prior byte kept");
      rd_byte(8'hAA, "R9 no increment on clash");
      rd_byte(8'h00, "R9 nothing stored");
   endtask

   task automatic t_single;
      set_addr(8'h50);
      bus_ad_i = 8'h12; wait_cyc(1);
      wr_i = 1'b1; wait_cyc(6);
      bus_ad_i = 8'h34; wait_cyc(10);
      wr_i = 1'b0; wait_cyc(6);
      set_addr(8'h50);
      rd_byte(8'h12, "R10 leading-edge value");
      rd_byte(8'h00, "R10 single increment");
   endtask

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      wait_cyc(4);
      t_reset;
      t_burst;
      t_wrap;
      t_override;
      t_clash;
      t_single;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule